// File: doc/BRIEF.md
# Processor Interrupt Pin Front End

This block stands between six processor control pins and the exception logic of a core. Pin activity arrives as update events: a valid strobe, a pin index and the newly sampled level. The block keeps the last level it saw on every defined pin and acts only when an update carries a different level. A repeated update with an unchanged level does nothing.

Each pin has its own sensitivity rule. Two pins are active-high level inputs that set and clear their own pending bits. One pin sets a pending bit only on a high-to-low change. One active-low pin stops the core while low, and one active-low pin requests a core reset while low. The soft reset pin drives a reset-class pending bit that follows its level. The pending vector, a combined request line, a halt output and a core reset request go to the core. The core can clear any pending bit with a one-cycle acknowledge strobe and a bit index, which is how an edge-latched bit is retired.

Top module: `irq_pin_frontend`

## Requirements
- R1: After reset all outputs are zero, and every stored pin level is zero.
- R2: An update on a defined pin whose level equals the stored level for that pin changes no output.
- R3: Pin index 0 (external interrupt) is active-high level: a change to 1 sets pending bit 0 and a change to 0 clears it, visible on the clock edge after the update.
- R4: Pin index 1 (management interrupt) is active-high level and drives pending bit 1 in the same way.
- R5: Pin index 2 (machine check) sets pending bit 2 on a change from 1 to 0; a change from 0 to 1 leaves the bit as it was.
- R6: Pin index 3 (checkstop) is active low: a change to 0 raises `halt_o`, a change to 1 lowers it.
- R7: Pin index 4 (hard reset) is active low: a change to 0 raises `core_rst_o`, a change to 1 lowers it.
- R8: Pin index 5 (soft reset) drives pending bit 3 following its level on each change.
- R9: Updates on pin indices 6 and 7 have no effect on any output.
- R10: `irq_o` is 1 in every cycle in which `pend_o` is nonzero and 0 when `pend_o` is all zero.
- R11: An acknowledge with `ack_valid` high clears pending bit `ack_idx` on the next edge; when a pin change sets the same bit in the same cycle, the bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_valid | input | 1 | Pin update strobe |
| upd_pin | input | IDX_W | Index of the pin being updated |
| upd_level | input | 1 | Newly sampled level of that pin |
| ack_valid | input | 1 | One-cycle pending-bit acknowledge strobe |
| ack_idx | input | CLR_W | Pending bit to clear |
| pend_o | output | PEND_W | Pending interrupt vector |
| irq_o | output | 1 | Combined interrupt request |
| halt_o | output | 1 | Core stop request |
| core_rst_o | output | 1 | Core reset request |

## Verification
Every result of an update or acknowledge presented before a rising edge is due right after that edge: the pending vector, halt and reset outputs are one register away from the inputs, and the combined request changes in the same cycle as the pending vector in both build variants. The bench drives inputs on the falling edge, holds them across exactly one rising edge, and compares all outputs with its model on the next falling edge, so each comparison sees the effect of precisely one applied step. Directed steps cover repeated levels, a rising edge on the machine check pin, unused indices and an acknowledge racing a set; a seeded random run mixes all of them.

// File: rtl/irq_pin_pkg.sv
package irq_pin_pkg;
   // pin indices on the update port
   localparam int PIN_EXT   = 0;
   localparam int PIN_SMI   = 1;
   localparam int PIN_MCHK  = 2;
   localparam int PIN_CKSTP = 3;
   localparam int PIN_HRST  = 4;
   localparam int PIN_SRST  = 5;
   localparam int NUM_PINS  = 6;

   // pending vector bit positions
   localparam int PB_EXT  = 0;
   localparam int PB_SMI  = 1;
   localparam int PB_MCHK = 2;
   localparam int PB_RST  = 3;
   localparam int NUM_PB  = 4;

   typedef enum logic [1:0] {
      SENSE_LVL_HIGH = 2'd0,
      SENSE_LVL_LOW  = 2'd1,
      SENSE_FALL     = 2'd2
   } sense_e;

   typedef struct packed {
      logic halt_set;
      logic halt_clr;
      logic rst_set;
      logic rst_clr;
   } core_ctl_t;
endpackage

// File: rtl/irq_pin_track.sv
module irq_pin_track #(
   parameter int IDX_W    = 3,
   parameter int NUM_PINS = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                upd_valid,
   input  logic [IDX_W-1:0]    upd_pin,
   input  logic                upd_level,
   output logic [NUM_PINS-1:0] lvl_q,
   output logic [NUM_PINS-1:0] chg
);
   // one level flop and one change detector per defined pin
   for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
      logic hit;
      logic q;
      assign hit = upd_valid && (upd_pin == IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   q <= 1'b0;
         else if (hit) q <= upd_level;
      end
      assign lvl_q[g] = q;
      assign chg[g]   = hit && (upd_level != q);
   end
endmodule

// File: rtl/irq_pin_map.sv
module irq_pin_map
   import irq_pin_pkg::*;
#(
   parameter int NUM_PINS = 6,
   parameter int PEND_W   = 4
) (
   input  logic [NUM_PINS-1:0] chg,
   input  logic                level,
   output logic [PEND_W-1:0]   pend_set,
   output logic [PEND_W-1:0]   pend_clr,
   output core_ctl_t           ctl
);
   // pins that feed a pending bit: index, bit, sensitivity
   localparam int NUM_IRQ_PINS = 4;

   function automatic int irq_pin_of(input int k);
      case (k)
         0:       return PIN_EXT;
         1:       return PIN_SMI;
         2:       return PIN_MCHK;
         default: return PIN_SRST;
      endcase
   endfunction

   function automatic int irq_bit_of(input int k);
      case (k)
         0:       return PB_EXT;
         1:       return PB_SMI;
         2:       return PB_MCHK;
         default: return PB_RST;
      endcase
   endfunction

   function automatic sense_e irq_sense_of(input int k);
      return (k == 2) ? SENSE_FALL : SENSE_LVL_HIGH;
   endfunction

   logic [NUM_IRQ_PINS-1:0] k_set;
   logic [NUM_IRQ_PINS-1:0] k_clr;

   for (genvar k = 0; k < NUM_IRQ_PINS; k++) begin : g_irq
      localparam int     PIN = irq_pin_of(k);
      localparam sense_e SNS = irq_sense_of(k);
      if (SNS == SENSE_FALL) begin : g_fall
         assign k_set[k] = chg[PIN] && !level;
         assign k_clr[k] = 1'b0;
      end else begin : g_lvl
         assign k_set[k] = chg[PIN] && level;
         assign k_clr[k] = chg[PIN] && !level;
      end
   end

   always_comb begin
      pend_set = '0;
      pend_clr = '0;
      for (int k = 0; k < NUM_IRQ_PINS; k++) begin
         pend_set[irq_bit_of(k)] = k_set[k];
         pend_clr[irq_bit_of(k)] = k_clr[k];
      end
   end

   // active-low control pins
   always_comb begin
      ctl.halt_set = chg[PIN_CKSTP] && !level;
      ctl.halt_clr = chg[PIN_CKSTP] &&  level;
      ctl.rst_set  = chg[PIN_HRST]  && !level;
      ctl.rst_clr  = chg[PIN_HRST]  &&  level;
   end
endmodule

// File: rtl/irq_pend_store.sv
module irq_pend_store #(
   parameter int PEND_W  = 4,
   parameter int IRQ_REG = 0,
   parameter int CLR_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PEND_W-1:0] pend_set,
   input  logic [PEND_W-1:0] pend_clr,
   input  logic              ack_valid,
   input  logic [CLR_W-1:0]  ack_idx,
   output logic [PEND_W-1:0] pend_q,
   output logic              irq
);
   logic [PEND_W-1:0] ack_vec;
   logic [PEND_W-1:0] pend_d;

   for (genvar b = 0; b < PEND_W; b++) begin : g_ack
      assign ack_vec[b] = ack_valid && (ack_idx == CLR_W'(b));
   end

   // a set in the same cycle wins over any clear
   assign pend_d = (pend_q & ~(pend_clr | ack_vec)) | pend_set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_d;
   end

   if (IRQ_REG != 0) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= |pend_d;
      end
      assign irq = irq_q;
   end else begin : g_irq_or
      assign irq = |pend_q;
   end
endmodule

// File: rtl/irq_pin_frontend.sv
module irq_pin_frontend
   import irq_pin_pkg::*;
#(
   parameter int IDX_W   = 3,
   parameter int PEND_W  = 4,
   parameter int IRQ_REG = 0,
   localparam int CLR_W  = (PEND_W > 1) ? $clog2(PEND_W) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_valid,
   input  logic [IDX_W-1:0]  upd_pin,
   input  logic              upd_level,
   input  logic              ack_valid,
   input  logic [CLR_W-1:0]  ack_idx,
   output logic [PEND_W-1:0] pend_o,
   output logic              irq_o,
   output logic              halt_o,
   output logic              core_rst_o
);
   if ((1 << IDX_W) < NUM_PINS) begin : g_bad_idx
      $error("IDX_W too narrow for the defined pins");
   end
   if (PEND_W < NUM_PB) begin : g_bad_pend
      $error("PEND_W must hold every pending bit");
   end

   logic [NUM_PINS-1:0] lvl_q;
   logic [NUM_PINS-1:0] chg;
   logic [PEND_W-1:0]   pend_set;
   logic [PEND_W-1:0]   pend_clr;
   core_ctl_t           ctl;
   logic                halt_q;
   logic                crst_q;

   irq_pin_track #(.IDX_W(IDX_W), .NUM_PINS(NUM_PINS)) u_track (
      .clk(clk), .rst_n(rst_n),
      .upd_valid(upd_valid), .upd_pin(upd_pin), .upd_level(upd_level),
      .lvl_q(lvl_q), .chg(chg)
   );

   irq_pin_map #(.NUM_PINS(NUM_PINS), .PEND_W(PEND_W)) u_map (
      .chg(chg), .level(upd_level),
      .pend_set(pend_set), .pend_clr(pend_clr), .ctl(ctl)
   );

   irq_pend_store #(.PEND_W(PEND_W), .IRQ_REG(IRQ_REG), .CLR_W(CLR_W)) u_pend (
      .clk(clk), .rst_n(rst_n),
      .pend_set(pend_set), .pend_clr(pend_clr),
      .ack_valid(ack_valid), .ack_idx(ack_idx),
      .pend_q(pend_o), .irq(irq_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_q <= 1'b0;
         crst_q <= 1'b0;
      end else begin
         if (ctl.halt_set)      halt_q <= 1'b1;
         else if (ctl.halt_clr) halt_q <= 1'b0;
         if (ctl.rst_set)       crst_q <= 1'b1;
         else if (ctl.rst_clr)  crst_q <= 1'b0;
      end
   end

   assign halt_o     = halt_q;
   assign core_rst_o = crst_q;
endmodule

// File: rtl/irq_pin_frontend_chk.sv
module irq_pin_frontend_chk
   import irq_pin_pkg::*;
#(
   parameter int IDX_W  = 3,
   parameter int PEND_W = 4,
   parameter int CLR_W  = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                upd_valid,
   input logic [IDX_W-1:0]    upd_pin,
   input logic                upd_level,
   input logic                ack_valid,
   input logic [CLR_W-1:0]    ack_idx,
   input logic [NUM_PINS-1:0] lvl_q,
   input logic [PEND_W-1:0]   pend_o,
   input logic                irq_o,
   input logic                halt_o,
   input logic                core_rst_o
);
   logic defined_pin;
   logic same_lvl;
   assign defined_pin = int'(upd_pin) < NUM_PINS;
   assign same_lvl    = defined_pin && (upd_level == lvl_q[int'(upd_pin) % NUM_PINS]);

   a_r2_same_level_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid && same_lvl && !ack_valid |=>
         $stable(pend_o) && $stable(halt_o) && $stable(core_rst_o));

   a_r3_ext_follows: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid && upd_pin == IDX_W'(PIN_EXT) && !same_lvl |=>
         pend_o[PB_EXT] == $past(upd_level));

   a_r5_mchk_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid && upd_pin == IDX_W'(PIN_MCHK) && !upd_level && lvl_q[PIN_MCHK] |=>
         pend_o[PB_MCHK]);

   a_r5_mchk_rise_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid && upd_pin == IDX_W'(PIN_MCHK) && upd_level && !ack_valid
         && pend_o[PB_MCHK] |=> pend_o[PB_MCHK]);

   a_r6_halt_on_low: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid && upd_pin == IDX_W'(PIN_CKSTP) && !upd_level && lvl_q[PIN_CKSTP] |=>
         halt_o);

   a_r7_rst_on_low: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid && upd_pin == IDX_W'(PIN_HRST) && !upd_level && lvl_q[PIN_HRST] |=>
         core_rst_o);

   a_r9_unused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid && !defined_pin && !ack_valid |=>
         $stable(pend_o) && $stable(halt_o) && $stable(core_rst_o));

   a_r10_irq_high: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o != '0) |-> irq_o);

   a_r10_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o == '0) |-> !irq_o);

   a_r11_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid && !upd_valid && int'(ack_idx) < PEND_W |=>
         pend_o[int'($past(ack_idx)) % PEND_W] == 1'b0);
endmodule

bind irq_pin_frontend irq_pin_frontend_chk #(
   .IDX_W(IDX_W), .PEND_W(PEND_W), .CLR_W(CLR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .upd_valid(upd_valid), .upd_pin(upd_pin), .upd_level(upd_level),
   .ack_valid(ack_valid), .ack_idx(ack_idx),
   .lvl_q(lvl_q), .pend_o(pend_o), .irq_o(irq_o),
   .halt_o(halt_o), .core_rst_o(core_rst_o)
);

// File: tb/irq_pin_frontend_bench.sv
`timescale 1ns/1ps
module irq_pin_frontend_bench;
   localparam int IDX_W  = 3;
   localparam int PEND_W = 4;
   localparam int CLR_W  = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              upd_valid = 1'b0;
   logic [IDX_W-1:0]  upd_pin = '0;
   logic              upd_level = 1'b0;
   logic              ack_valid = 1'b0;
   logic [CLR_W-1:0]  ack_idx = '0;
   logic [PEND_W-1:0] pend_o;
   logic              irq_o, halt_o, core_rst_o;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   // model state
   logic [7:0]        m_lvl  = '0;
   logic [PEND_W-1:0] m_pend = '0;
   logic              m_halt = 1'b0;
   logic              m_rst  = 1'b0;

   always #2.5 clk = ~clk;

   irq_pin_frontend #(.IDX_W(IDX_W), .PEND_W(PEND_W)) u_irq_pin_frontend (
      .clk(clk), .rst_n(rst_n),
      .upd_valid(upd_valid), .upd_pin(upd_pin), .upd_level(upd_level),
      .ack_valid(ack_valid), .ack_idx(ack_idx),
      .pend_o(pend_o), .irq_o(irq_o), .halt_o(halt_o), .core_rst_o(core_rst_o)
   );

   task automatic chk(input string req, input string ctx, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s (%s): actual=%0h expected=%0h", req, ctx, act, exp);
      end
   endtask

   task automatic check_all(input string ctx);
      chk("R3", ctx, int'(pend_o[0]), int'(m_pend[0]));
      chk("R4", ctx, int'(pend_o[1]), int'(m_pend[1]));
      chk("R5", ctx, int'(pend_o[2]), int'(m_pend[2]));
      chk("R8", ctx, int'(pend_o[3]), int'(m_pend[3]));
      chk("R10", ctx, int'(irq_o), int'(m_pend != '0));
      chk("R6", ctx, int'(halt_o), int'(m_halt));
      chk("R7", ctx, int'(core_rst_o), int'(m_rst));
   endtask

   // expected effect of one step, from the requirements
   task automatic model_apply(input bit ev, input int pin, input bit lvl,
                              input bit av, input int aidx);
      logic [PEND_W-1:0] s = '0, c = '0, a = '0;
      if (ev && pin < 6 && lvl != m_lvl[pin]) begin
         case (pin)
            0: if (lvl) s[0] = 1'b1; else c[0] = 1'b1;
            1: if (lvl) s[1] = 1'b1; else c[1] = 1'b1;
            2: if (!lvl) s[2] = 1'b1;
            3: m_halt = !lvl;
            4: m_rst  = !lvl;
            default: if (lvl) s[3] = 1'b1; else c[3] = 1'b1;
         endcase
      end
      if (ev && pin < 6) m_lvl[pin] = lvl;
      if (av) a[aidx] = 1'b1;
      m_pend = (m_pend & ~(c | a)) | s;
   endtask

   task automatic step(input bit ev, input int pin, input bit lvl,
                       input bit av, input int aidx, input string ctx);
      upd_valid = ev;
      upd_pin   = IDX_W'(pin);
      upd_level = lvl;
      ack_valid = av;
      ack_idx   = CLR_W'(aidx);
      model_apply(ev, pin, lvl, av, aidx);
      @(negedge clk);
      upd_valid = 1'b0;
      ack_valid = 1'b0;
      check_all(ctx);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "reset pend", int'(pend_o), 0);
      chk("R1", "reset irq", int'(irq_o), 0);
      chk("R1", "reset halt", int'(halt_o), 0);
      chk("R1", "reset core_rst", int'(core_rst_o), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: repeated low on active-low pins does nothing after reset
      step(1, 3, 0, 0, 0, "R2 ckstp low repeat");
      step(1, 4, 0, 0, 0, "R2 hrst low repeat");
      // R3 / R2: ext set, ack, then same level must not re-set
      step(1, 0, 1, 0, 0, "R3 ext high");
      step(0, 0, 0, 1, 0, "R11 ack ext");
      step(1, 0, 1, 0, 0, "R2 ext high again");
      step(1, 0, 0, 0, 0, "R3 ext low");
      // R4
      step(1, 1, 1, 0, 0, "R4 smi high");
      step(1, 1, 0, 0, 0, "R4 smi low");
      // R5: rise no set, fall sets, rise keeps
      step(1, 2, 1, 0, 0, "R5 mchk rise");
      step(1, 2, 0, 0, 0, "R5 mchk fall");
      step(1, 2, 1, 0, 0, "R5 mchk rise keeps");
      step(0, 0, 0, 1, 2, "R11 ack mchk");
      // R6 / R7
      step(1, 3, 1, 0, 0, "R6 ckstp high");
      step(1, 3, 0, 0, 0, "R6 ckstp low halts");
      step(1, 3, 1, 0, 0, "R6 ckstp release");
      step(1, 4, 1, 0, 0, "R7 hrst high");
      step(1, 4, 0, 0, 0, "R7 hrst low");
      step(1, 4, 1, 0, 0, "R7 hrst release");
      // R8
      step(1, 5, 1, 0, 0, "R8 srst high");
      step(1, 5, 0, 0, 0, "R8 srst low");
      // R9: unused indices
      step(1, 0, 1, 0, 0, "R9 prep");
      step(1, 6, 1, 0, 0, "R9 pin6 high");
      step(1, 7, 0, 0, 0, "R9 pin7 low");
      step(1, 7, 1, 0, 0, "R9 pin7 high");
      // R11: set wins over ack of same bit in same cycle
      step(1, 2, 0, 1, 2, "R11 fall with ack");
      step(1, 0, 0, 1, 1, "R11 ack other bit");

      // seeded random mix
      void'($urandom(32'd20240611));
      for (int i = 0; i < 3000; i++) begin
         step(($urandom % 10) < 8, int'($urandom % 8), bit'($urandom % 2),
              ($urandom % 5) == 0, int'($urandom % 4), "random");
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule